// File: doc/BRIEF.md
# Prescaled Dual-Channel Input-Capture Timer

This block timestamps edges on two input pins. A 16-bit counter runs from the bus clock and advances on a count enable. The enable is either a power-of-two division of the bus clock or the rising edges of an external clock pin. A 3-bit rate field in a control byte selects the source. Each capture channel watches its own pin through a synchroniser. When the programmed edge arrives, the channel copies the counter into a 16-bit capture register and raises a status flag. If the channel's interrupt enable is set, the flag also drives the channel's interrupt line.

Software reaches everything through a byte-wide register port. Writes are single-cycle strobes. Reads return the addressed byte combinationally, and the read strobe carries the side effects. The address map is: 0 control (rate field in bits 2:0), 1 counter high byte, 2 counter low byte. Channel c (c = 0, 1) sits at base 4·(c+1): offset 0 is its status/control byte, offset 1 the capture high byte and offset 2 the capture low byte. Every other address reads 0.

A 16-bit capture can be read safely even while edges keep arriving. A read strobe on the high byte holds the register until the low byte is read. A capture that lands in the meantime is parked and applied afterwards.

Top module: `dual_capture_timer`

## Requirements
- R1: With rate field values 0 to 6, the counter advances by exactly one every 2^rate bus clocks; a divider that runs freely from reset sets the phase.
- R2: With rate field value 7, the counter advances once for each rising edge of the external clock pin, seen through a two-flop synchroniser. The counter is 16 bits wide, resets to 0, wraps, and reads as address 1 (high byte) and address 2 (low byte).
- R3: On a qualifying edge, the channel's capture register takes the value the counter held in the cycle the edge was detected. It reads as the high byte at base+1 and the low byte at base+2.
- R4: The edge-select field is status/control bits 3:2: 00 no capture, 01 rising, 10 falling, 11 both. Capture is active only while the mode bits (bits 5:4) are 00; any other mode value makes the pin ignored.
- R5: A capture sets the flag in bit 7. The channel's interrupt output equals the flag ANDed with the enable in bit 6.
- R6: The flag clears only when a read strobe of the status/control byte sees it set and a later write puts 0 in bit 7. A capture between that read and the write keeps the flag set, and a write alone never clears it.
- R7: A capture overwrites the capture register even when the flag is still set.
- R8: Status/control layout is bit7 flag, bit6 enable, bit5 mode-high, bit4 mode-low, bits3:2 edge-select, bit1 toggle-on-overflow, bit0 max-duty. Bits 6..0 are stored as written. Bit 5 reads 0 on channel 1. All of these reset to 0, and the control byte returns the rate field in bits 2:0.
- R9: After a read strobe of the capture high byte, the register holds until its low byte is read. A capture in between shows only after that low-byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk_in | input | 1 | External count pin, used when the rate field is 7 |
| cap_in | input | 2 | Capture pins, one per channel |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (carries read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The bench targets the race in the flag-clear sequence. A capture arrives between the arming read and the clearing write; a design that cleared on the write alone would silently drop that event. It also tears a 16-bit read by capturing between the high and low byte reads. A design without the hold would return a low byte from a different event. The divider ratios and the external-pin mode are measured over fixed windows, where an off-by-one divider or a level-sensitive pin would show as a wrong count. Polarity is checked per channel, including the disabled and non-capture modes, together with captures that overwrite while the flag is still pending.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      ie;
    logic      msb;
    logic      msa;
    edge_sel_e els;
    logic      tov;
    logic      max;
  } ch_cfg_t;
endpackage

// File: rtl/ct_sync.sv
module ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps,
  input  logic            ext_s,
  output logic            tick
);
  localparam int              DIV_W  = (1 << PS_W) - 2;
  localparam logic [PS_W-1:0] PS_EXT = '1;

  logic [DIV_W-1:0] div_q, div_d, mask;
  logic             ext_q;

  always_comb begin
    div_d = div_q + 1'b1;
    mask  = DIV_W'((DIV_W'(1) << ps) - DIV_W'(1));
    if (ps == PS_EXT) tick = ext_s & ~ext_q;
    else              tick = &(div_q | ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= 1'b0;
    end else begin
      div_q <= div_d;
      ext_q <= ext_s;
    end
  end
endmodule

// File: rtl/ct_channel.sv
module ct_channel
  import ct_pkg::*;
#(
  parameter bit HAS_MSB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             pin_s,
  input  logic             wr_sc,
  input  logic             rd_sc,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic [7:0]       wdata,
  output logic [7:0]       sc_out,
  output logic [7:0]       hi_out,
  output logic [7:0]       lo_out,
  output logic             irq
);
  logic             pin_q, rise, fall, hit;
  ch_cfg_t          cfg_q, cfg_d;
  logic             flag_q, flag_d, arm_q, arm_d;
  logic             lock_q, lock_d, pend_q, pend_d;
  logic [CNT_W-1:0] cap_q, cap_d, pv_q, pv_d;

  // edge qualification
  always_comb begin
    rise = pin_s & ~pin_q;
    fall = ~pin_s & pin_q;
    hit  = 1'b0;
    if (!cfg_q.msb && !cfg_q.msa) begin
      case (cfg_q.els)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  // next state
  always_comb begin
    cfg_d  = cfg_q;
    arm_d  = arm_q;
    lock_d = lock_q;
    pend_d = pend_q;
    cap_d  = cap_q;
    pv_d   = pv_q;
    flag_d = hit | (flag_q & ~(wr_sc & ~wdata[7] & arm_q));
    if (wr_sc) begin
      cfg_d.ie  = wdata[6];
      cfg_d.msb = HAS_MSB ? wdata[5] : 1'b0;
      cfg_d.msa = wdata[4];
      cfg_d.els = edge_sel_e'(wdata[3:2]);
      cfg_d.tov = wdata[1];
      cfg_d.max = wdata[0];
      arm_d     = 1'b0;
    end else if (rd_sc && flag_q) begin
      arm_d = 1'b1;
    end
    if (hit) arm_d = 1'b0;
    if (rd_lo) begin
      lock_d = 1'b0;
      pend_d = 1'b0;
      if (hit)         cap_d = cnt;
      else if (pend_q) cap_d = pv_q;
    end else begin
      if (hit) begin
        if (lock_q || rd_hi) begin
          pend_d = 1'b1;
          pv_d   = cnt;
        end else begin
          cap_d = cnt;
        end
      end
      if (rd_hi) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      cfg_q  <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      lock_q <= 1'b0;
      pend_q <= 1'b0;
      cap_q  <= '0;
      pv_q   <= '0;
    end else begin
      pin_q  <= pin_s;
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
      arm_q  <= arm_d;
      lock_q <= lock_d;
      pend_q <= pend_d;
      cap_q  <= cap_d;
      pv_q   <= pv_d;
    end
  end

  assign sc_out = {flag_q, cfg_q.ie, cfg_q.msb, cfg_q.msa, cfg_q.els, cfg_q.tov, cfg_q.max};
  assign hi_out = cap_q[CNT_W-1 -: 8];
  assign lo_out = cap_q[7:0];
  assign irq    = flag_q & cfg_q.ie;

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_sc && !wdata[7]));

  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rd_lo) |=> $stable(cap_q));
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import ct_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_in,
  input  logic [N_CH-1:0]   cap_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [N_CH-1:0]   irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNTH = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CNTL = ADDR_W'(2);

  logic             rst_i_n, ext_s, tick;
  logic [PS_W-1:0]  ps_q, ps_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       sc_v [N_CH];
  logic [7:0]       hi_v [N_CH];
  logic [7:0]       lo_v [N_CH];

  ct_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_i_n));

  ct_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_i_n), .d(ext_clk_in), .q(ext_s));

  ct_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_i_n), .ps(ps_q), .ext_s(ext_s), .tick(tick));

  always_comb begin
    ps_d  = (bus_wr && bus_addr == A_CTRL) ? bus_wdata[PS_W-1:0] : ps_q;
    cnt_d = cnt_q + CNT_W'(tick);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      ps_q  <= ps_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * (g + 1));
    logic pin_s;

    ct_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_i_n), .d(cap_in[g]), .q(pin_s));

    ct_channel #(.HAS_MSB(g == 0)) u_ch (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .cnt    (cnt_q),
      .pin_s  (pin_s),
      .wr_sc  (bus_wr && bus_addr == BASE),
      .rd_sc  (bus_rd && bus_addr == BASE),
      .rd_hi  (bus_rd && bus_addr == BASE + ADDR_W'(1)),
      .rd_lo  (bus_rd && bus_addr == BASE + ADDR_W'(2)),
      .wdata  (bus_wdata),
      .sc_out (sc_v[g]),
      .hi_out (hi_v[g]),
      .lo_out (lo_v[g]),
      .irq    (irq[g]));
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = 8'(ps_q);
      A_CNTH:  bus_rdata = cnt_q[CNT_W-1 -: 8];
      A_CNTL:  bus_rdata = cnt_q[7:0];
      default: bus_rdata = '0;
    endcase
    for (int c = 0; c < N_CH; c++) begin
      if (bus_addr == ADDR_W'(4 * (c + 1)))     bus_rdata = sc_v[c];
      if (bus_addr == ADDR_W'(4 * (c + 1) + 1)) bus_rdata = hi_v[c];
      if (bus_addr == ADDR_W'(4 * (c + 1) + 2)) bus_rdata = lo_v[c];
    end
  end

  // R1
  div_one_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ps_q == '0) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: tb/dual_capture_timer_tb.sv
module dual_capture_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic [1:0] cap_in = 2'b00;
  logic [3:0] bus_addr = 4'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] irq;

  int n_chk = 0, n_err = 0;
  bit cmp_on = 0, done = 0;

  always #5 clk = ~clk;

  dual_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .cap_in(cap_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference state
  int m_ps, m_cnt, m_div, m_em, m_es, m_ed, rcnt;
  int m_cm[2], m_cs[2], m_cd[2], m_flag[2], m_ie[2], m_msb[2], m_msa[2];
  int m_els[2], m_tov[2], m_max[2], m_cap[2], m_lock[2], m_pend[2], m_pv[2], m_arm[2];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sc_of(int c);
    return (m_flag[c] << 7) | (m_ie[c] << 6) | (m_msb[c] << 5) | (m_msa[c] << 4) |
           (m_els[c] << 2) | (m_tov[c] << 1) | m_max[c];
  endfunction

  function automatic int exp_rdata(int a);
    case (a)
      0: return m_ps;
      1: return m_cnt >> 8;
      2: return m_cnt & 255;
      4: return sc_of(0);
      5: return m_cap[0] >> 8;
      6: return m_cap[0] & 255;
      8: return sc_of(1);
      9: return m_cap[1] >> 8;
      10: return m_cap[1] & 255;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a == 1 || a == 2) return "R2 counter";
    if (a == 5 || a == 6 || a == 9 || a == 10) return "R3 capture";
    return "R8 register";
  endfunction

  task automatic model_step();
    int tick, a, wd, base, rise, fall, hit, rsc, rhi, rlo, wsc, of, oa;
    a = int'(bus_addr);
    wd = int'(bus_wdata);
    if (m_ps == 7) tick = (m_es == 1 && m_ed == 0) ? 1 : 0;
    else tick = ((m_div % (1 << m_ps)) == (1 << m_ps) - 1) ? 1 : 0;
    for (int c = 0; c < 2; c++) begin
      rise = (m_cs[c] == 1 && m_cd[c] == 0) ? 1 : 0;
      fall = (m_cs[c] == 0 && m_cd[c] == 1) ? 1 : 0;
      hit = (m_msb[c] == 0 && m_msa[c] == 0 &&
             ((m_els[c] == 1 && rise == 1) || (m_els[c] == 2 && fall == 1) ||
              (m_els[c] == 3 && (rise == 1 || fall == 1)))) ? 1 : 0;
      base = 4 * (c + 1);
      rsc = (bus_rd && a == base) ? 1 : 0;
      rhi = (bus_rd && a == base + 1) ? 1 : 0;
      rlo = (bus_rd && a == base + 2) ? 1 : 0;
      wsc = (bus_wr && a == base) ? 1 : 0;
      of = m_flag[c];
      oa = m_arm[c];
      m_flag[c] = (hit == 1 || (of == 1 && !(wsc == 1 && (wd & 128) == 0 && oa == 1))) ? 1 : 0;
      if (wsc == 1) m_arm[c] = 0;
      else if (rsc == 1 && of == 1) m_arm[c] = 1;
      if (hit == 1) m_arm[c] = 0;
      if (wsc == 1) begin
        m_ie[c]  = (wd >> 6) & 1;
        m_msb[c] = (c == 0) ? (wd >> 5) & 1 : 0;
        m_msa[c] = (wd >> 4) & 1;
        m_els[c] = (wd >> 2) & 3;
        m_tov[c] = (wd >> 1) & 1;
        m_max[c] = wd & 1;
      end
      if (rlo == 1) begin
        if (hit == 1) m_cap[c] = m_cnt;
        else if (m_pend[c] == 1) m_cap[c] = m_pv[c];
        m_pend[c] = 0;
        m_lock[c] = 0;
      end else begin
        if (hit == 1) begin
          if (m_lock[c] == 1 || rhi == 1) begin m_pend[c] = 1; m_pv[c] = m_cnt; end
          else m_cap[c] = m_cnt;
        end
        if (rhi == 1) m_lock[c] = 1;
      end
      m_cd[c] = m_cs[c];
      m_cs[c] = m_cm[c];
      m_cm[c] = int'(cap_in[c]);
    end
    if (bus_wr && a == 0) m_ps = wd & 7;
    m_div = (m_div + 1) % 64;
    m_cnt = (m_cnt + tick) % 65536;
    m_ed = m_es;
    m_es = m_em;
    m_em = int'(ext_clk_in);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; m_ps = 0; m_cnt = 0; m_div = 0; m_em = 0; m_es = 0; m_ed = 0;
      for (int c = 0; c < 2; c++) begin
        m_cm[c] = 0; m_cs[c] = 0; m_cd[c] = 0; m_flag[c] = 0; m_ie[c] = 0; m_msb[c] = 0;
        m_msa[c] = 0; m_els[c] = 0; m_tov[c] = 0; m_max[c] = 0; m_cap[c] = 0;
        m_lock[c] = 0; m_pend[c] = 0; m_pv[c] = 0; m_arm[c] = 0;
      end
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      model_step();
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(tag_of(int'(bus_addr)), 32'(bus_rdata), 32'(exp_rdata(int'(bus_addr))));
      check("R5 irq", 32'(irq),
            32'(((m_flag[1] & m_ie[1]) << 1) | (m_flag[0] & m_ie[0])));
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #2;
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #2;
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); #2;
    bus_addr = 4'(a); bus_rd = 1'b1; bus_wr = 1'b0;
    #1 d = int'(bus_rdata);
    @(negedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic peek(int a, output int d);
    @(negedge clk); #2;
    bus_addr = 4'(a); bus_rd = 1'b0; bus_wr = 1'b0;
    #1 d = int'(bus_rdata);
  endtask

  task automatic pin(int c, logic v);
    @(negedge clk); #2;
    cap_in[c] = v;
    idle(4);
  endtask

  initial begin
    int a, b, h, l, v, c1, c2, lo_old;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    idle(3);
    cmp_on = 1;

    // reset state
    peek(0, v);  check("R8 reset ctrl", 32'(v), 32'h0);
    peek(4, v);  check("R8 reset sc0", 32'(v), 32'h0);
    peek(8, v);  check("R8 reset sc1", 32'(v), 32'h0);
    check("R5 reset irq", 32'(irq), 32'h0);

    // R1: divide by 1 and by 8
    rd(2, a); idle(8); rd(2, b);
    check("R1 div1 count", 32'((b - a) & 255), 32'd10);
    wr(0, 3); rd(2, a); idle(62); rd(2, b);
    check("R1 div8 count", 32'((b - a) & 255), 32'd8);

    // R2: external pin counting
    wr(0, 7); idle(4); rd(2, a);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #2 ext_clk_in = 1'b1; idle(3);
      @(negedge clk); #2 ext_clk_in = 1'b0; idle(3);
    end
    idle(4); rd(2, b);
    check("R2 ext edges", 32'((b - a) & 255), 32'd5);
    rd(0, v); check("R8 ctrl readback", 32'(v), 32'd7);

    // R3: capture of a frozen counter
    rd(1, h); rd(2, l);
    wr(4, 8'h44);
    pin(0, 1'b1);
    rd(5, v); check("R3 cap hi", 32'(v), 32'(h));
    rd(6, v); check("R3 cap lo", 32'(v), 32'(l));
    check("R5 irq after capture", 32'(irq[0]), 32'd1);

    // R6: write alone does not clear; read then write does
    wr(4, 8'h44); idle(1);
    check("R6 write-only keeps flag", 32'(irq[0]), 32'd1);
    rd(4, v); check("R8 sc0 with flag", 32'(v), 32'hC4);
    wr(4, 8'h44); idle(1);
    check("R6 flag cleared", 32'(irq[0]), 32'd0);

    // R4: falling edge ignored in rising mode; R7 overwrite with flag set
    wr(0, 0);
    pin(0, 1'b0);
    peek(4, v); check("R4 fall ignored", 32'(v), 32'h44);
    pin(0, 1'b1);
    rd(5, h); rd(6, l); c1 = (h << 8) | l;
    pin(0, 1'b0); pin(0, 1'b1);
    rd(5, h); rd(6, l); c2 = (h << 8) | l;
    check("R7 overwrite while flagged", 32'(c2 != c1), 32'd1);
    check("R7 cap matches model", 32'(c2), 32'(m_cap[0]));

    // R6: capture between arming read and clearing write
    rd(4, v);
    pin(0, 1'b0); pin(0, 1'b1);
    wr(4, 8'h44); idle(1);
    check("R6 race keeps flag", 32'(irq[0]), 32'd1);
    rd(4, v); wr(4, 8'h44); idle(1);
    check("R6 clear after race", 32'(irq[0]), 32'd0);

    // R4: channel 1 falling, both, disabled
    wr(8, 8'h08);
    pin(1, 1'b1);
    peek(8, v); check("R4 ch1 rise ignored", 32'(v), 32'h08);
    pin(1, 1'b0);
    rd(8, v); check("R4 ch1 fall captured", 32'(v), 32'h88);
    wr(8, 8'h0C);
    pin(1, 1'b1);
    rd(8, v); check("R4 both rise", 32'(v), 32'h8C);
    wr(8, 8'h0C);
    pin(1, 1'b0);
    rd(8, v); check("R4 both fall", 32'(v), 32'h8C);
    wr(8, 8'h00);
    rd(9, h); rd(10, l); c1 = (h << 8) | l;
    pin(1, 1'b1); pin(1, 1'b0);
    peek(8, v); check("R4 off no flag", 32'(v), 32'h00);
    rd(9, h); rd(10, l);
    check("R4 off no capture", 32'((h << 8) | l), 32'(c1));

    // R4: non-capture mode ignores pin
    wr(4, 8'h14);
    pin(0, 1'b0); pin(0, 1'b1);
    peek(4, v); check("R4 mode blocks capture", 32'(v), 32'h14);

    // R8: layout and reserved bit
    wr(8, 8'hFF); peek(8, v); check("R8 ch1 bit5 reserved", 32'(v), 32'h5F);
    wr(4, 8'h3F); peek(4, v); check("R8 ch0 all bits", 32'(v), 32'h3F);

    // R9: coherent 16-bit read across a capture
    wr(4, 8'h04);
    pin(0, 1'b0); pin(0, 1'b1);
    peek(6, lo_old);
    rd(5, h);
    pin(0, 1'b0); pin(0, 1'b1);
    rd(6, l);
    check("R9 low byte held", 32'(l), 32'(lo_old));
    idle(1);
    rd(5, h); rd(6, l);
    check("R9 pending applied", 32'((h << 8) | l), 32'(m_cap[0]));
    check("R9 new value differs", 32'(l != lo_old), 32'd1);

    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule